// File: doc/BRIEF.md
# Execution-Port Signature Checker and Spoiler

This block sits in front of one functional unit of an out-of-order core. Each operand value chosen by the operand-select mux carries a small signature naming the instruction that produced it. The block compares those two signatures against the source signatures the instruction was given at rename time. It then cross-checks the outcome against the independent replay indication from the load replay logic. A dataflow fault exists exactly when the two views disagree. On a fault, the block raises an error flag and a pipeline flush request for one cycle, together with the identifier of the faulting instruction, so that re-execution can restart from it.

The block also sends the instruction's destination signature out with the result, toward both the bypass network and register-file write-back. That signature is corrupted by an XOR mask when the result is poisoned. A result is poisoned when the instruction is a load that missed in the data cache, or when it consumed an operand whose signature did not match. Dependents of a missing load therefore inherit corrupted signatures, directly or through chains of consumers. The data computation itself is outside the block.

Top module: `sig_port_checker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `err_flag`, `flush_req` and `res_valid` are 0.
- R2: A source operand counts as mismatched when `issue_valid` is 1, its use bit is 1, and its arriving signature differs from its expected signature in any bit. The instruction is mismatched when either operand is mismatched.
- R3: An operand whose use bit is 0 never causes a mismatch, whatever its signatures are.
- R4: One cycle after a valid issue, `err_flag` is 1 exactly when mismatch and `replay_needed` differ. This gives four cases: neither set → 0, only replay set → 1, only mismatch set → 1, both set → 0.
- R5: `flush_req` equals `err_flag`. When it is 1, `flush_id` holds the `instr_id` of the issue one cycle earlier. Each fault raises these outputs for exactly one cycle.
- R6: When a valid issue has `is_load`=1, `load_miss`=1 and `dst_write`=1, then one cycle later `res_sig` = `dst_sig` XOR `SPOIL_MASK` (default mask: all ones).
- R7: When a valid issue with `dst_write`=1 is mismatched (R2), then one cycle later `res_sig` = `dst_sig` XOR `SPOIL_MASK`. This holds whether or not replay is set.
- R8: When a valid issue with `dst_write`=1 is neither mismatched nor a missing load, then one cycle later `res_valid`=1, `res_sig`=`dst_sig` and `res_tag`=`dst_tag`.
- R9: An issue with `issue_valid`=0 produces `res_valid`=0 and `err_flag`=0 one cycle later. An issue with `dst_write`=0 produces `res_valid`=0.
- R10: `load_miss` has no effect when `is_load` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is at the port this cycle |
| use_a | input | 1 | Instruction reads source A |
| use_b | input | 1 | Instruction reads source B |
| exp_sig_a | input | SIG_W | Expected signature of source A, from the issue queue |
| exp_sig_b | input | SIG_W | Expected signature of source B, from the issue queue |
| opnd_sig_a | input | SIG_W | Signature travelling with the selected value of source A |
| opnd_sig_b | input | SIG_W | Signature travelling with the selected value of source B |
| replay_needed | input | 1 | Replay indication from the load replay logic |
| is_load | input | 1 | Instruction is a load |
| load_miss | input | 1 | Load missed in the data cache |
| dst_write | input | 1 | Instruction writes a destination register |
| dst_sig | input | SIG_W | Destination signature assigned at rename |
| dst_tag | input | TAG_W | Destination physical register tag |
| instr_id | input | ID_W | Identifier of the issuing instruction |
| res_valid | output | 1 | Result signature and tag are being broadcast |
| res_sig | output | SIG_W | Broadcast destination signature, possibly spoiled |
| res_tag | output | TAG_W | Broadcast destination tag |
| err_flag | output | 1 | A dataflow fault was detected |
| flush_req | output | 1 | Pipeline flush request |
| flush_id | output | ID_W | Instruction to restart from |

## Verification
The assertions assume that inputs are stable around each rising edge and that they are held low during reset. They also assume that `replay_needed`, `is_load` and `load_miss` are only meaningful when `issue_valid` is 1. The bench drives every input on the falling edge, so each value is settled a half period before it is sampled. Random issues choose matching operand signatures most of the time and flip at least one bit otherwise. Use bits, replay, load and miss bits are drawn independently, so all four rows of the replay cross-check and both poison sources are reached. Directed cases cover unused mismatched operands, a miss on a non-load, and invalid issues carrying fault-like inputs.

// File: rtl/sig_chk_pkg.sv
package sig_chk_pkg;

   // Outcome of cross-checking signature comparison against replay
   typedef enum logic [1:0] {
      VD_AGREE        = 2'd0,  // both views agree, no fault
      VD_FALSE_REPLAY = 2'd1,  // replay asked for, operands matched
      VD_SILENT_BAD   = 2'd2   // operands mismatched, no replay asked
   } verdict_e;

   function automatic logic is_fault(verdict_e v);
      return v != VD_AGREE;
   endfunction

endpackage

// File: rtl/sig_eq_cmp.sv
module sig_eq_cmp #(
   parameter int SIG_W = 3
) (
   input  logic             active,
   input  logic [SIG_W-1:0] got_sig,
   input  logic [SIG_W-1:0] exp_sig,
   output logic             miss
);
   logic [SIG_W-1:0] diff;

   always_comb begin
      diff = got_sig ^ exp_sig;
      miss = active & (|diff);
   end

endmodule

// File: rtl/sig_verdict.sv
module sig_verdict
   import sig_chk_pkg::*;
(
   input  logic     valid,
   input  logic     mismatch,
   input  logic     replay,
   output verdict_e verdict
);
   always_comb begin
      verdict = VD_AGREE;
      if (valid) begin
         if (replay && !mismatch)      verdict = VD_FALSE_REPLAY;
         else if (mismatch && !replay) verdict = VD_SILENT_BAD;
      end
   end

endmodule

// File: rtl/sig_spoiler.sv
module sig_spoiler #(
   parameter int               SIG_W = 3,
   parameter logic [SIG_W-1:0] MASK  = '1
) (
   input  logic [SIG_W-1:0] sig_in,
   input  logic             poison,
   output logic [SIG_W-1:0] sig_out
);
   generate
      if (MASK == '0) begin : g_bad_mask
         $error("sig_spoiler: MASK must be nonzero");
      end
   endgenerate

   always_comb sig_out = poison ? (sig_in ^ MASK) : sig_in;

endmodule

// File: rtl/sig_port_checker.sv
module sig_port_checker
   import sig_chk_pkg::*;
#(
   parameter int               SIG_W      = 3,
   parameter int               TAG_W      = 7,
   parameter int               ID_W       = 6,
   parameter logic [SIG_W-1:0] SPOIL_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_valid,
   input  logic             use_a,
   input  logic             use_b,
   input  logic [SIG_W-1:0] exp_sig_a,
   input  logic [SIG_W-1:0] exp_sig_b,
   input  logic [SIG_W-1:0] opnd_sig_a,
   input  logic [SIG_W-1:0] opnd_sig_b,
   input  logic             replay_needed,
   input  logic             is_load,
   input  logic             load_miss,
   input  logic             dst_write,
   input  logic [SIG_W-1:0] dst_sig,
   input  logic [TAG_W-1:0] dst_tag,
   input  logic [ID_W-1:0]  instr_id,
   output logic             res_valid,
   output logic [SIG_W-1:0] res_sig,
   output logic [TAG_W-1:0] res_tag,
   output logic             err_flag,
   output logic             flush_req,
   output logic [ID_W-1:0]  flush_id
);
   localparam int NSRC = 2;

   generate
      if (SIG_W < 1 || SIG_W > 16) begin : g_bad_sig
         $error("sig_port_checker: SIG_W out of range");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("sig_port_checker: TAG_W must be positive");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("sig_port_checker: ID_W must be positive");
      end
   endgenerate

   logic [NSRC-1:0]            src_use;
   logic [NSRC-1:0][SIG_W-1:0] src_got;
   logic [NSRC-1:0][SIG_W-1:0] src_exp;
   logic [NSRC-1:0]            src_miss;

   always_comb begin
      src_use = {use_b, use_a};
      src_got = {opnd_sig_b, opnd_sig_a};
      src_exp = {exp_sig_b, exp_sig_a};
   end

   // One comparator per source operand
   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_cmp
         sig_eq_cmp #(.SIG_W(SIG_W)) u_cmp (
            .active  (issue_valid & src_use[s]),
            .got_sig (src_got[s]),
            .exp_sig (src_exp[s]),
            .miss    (src_miss[s])
         );
      end
   endgenerate

   logic mismatch;
   always_comb mismatch = |src_miss;

   verdict_e verdict;
   sig_verdict u_verdict (
      .valid    (issue_valid),
      .mismatch (mismatch),
      .replay   (replay_needed),
      .verdict  (verdict)
   );

   logic poison;
   logic [SIG_W-1:0] out_sig;
   always_comb poison = (is_load & load_miss) | mismatch;

   sig_spoiler #(.SIG_W(SIG_W), .MASK(SPOIL_MASK)) u_spoil (
      .sig_in  (dst_sig),
      .poison  (poison),
      .sig_out (out_sig)
   );

   logic fault;
   always_comb fault = is_fault(verdict);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_sig   <= '0;
         res_tag   <= '0;
         err_flag  <= 1'b0;
         flush_req <= 1'b0;
         flush_id  <= '0;
      end else begin
         res_valid <= issue_valid & dst_write;
         res_sig   <= out_sig;
         res_tag   <= dst_tag;
         err_flag  <= fault;
         flush_req <= fault;
         flush_id  <= fault ? instr_id : flush_id;
      end
   end

   AST_ERR_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> !err_flag && !res_valid); // R9
   AST_AGREE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && (mismatch == replay_needed) |=> !err_flag); // R4
   AST_DISAGREE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && (mismatch != replay_needed) |=> err_flag && flush_req); // R4
   AST_UNUSED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && !use_a && !use_b |-> !mismatch); // R3
   AST_FLUSH_ID: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && (mismatch != replay_needed) |=> flush_id == $past(instr_id)); // R5
   AST_LOAD_SPOIL: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && dst_write && is_load && load_miss
      |=> res_sig == ($past(dst_sig) ^ SPOIL_MASK)); // R6
   AST_CHAIN_SPOIL: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && dst_write && mismatch
      |=> res_sig == ($past(dst_sig) ^ SPOIL_MASK)); // R7
   AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && dst_write && !mismatch && !(is_load && load_miss)
      |=> res_valid && res_sig == $past(dst_sig) && res_tag == $past(dst_tag)); // R8

endmodule

// File: tb/sig_port_checker_test.sv
module sig_port_checker_test;
   localparam int CLK_PERIOD = 10;
   localparam int SIG_W = 3;
   localparam int TAG_W = 7;
   localparam int ID_W  = 6;
   localparam logic [SIG_W-1:0] MASK = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic issue_valid = 0, use_a = 0, use_b = 0;
   logic [SIG_W-1:0] exp_sig_a = 0, exp_sig_b = 0, opnd_sig_a = 0, opnd_sig_b = 0;
   logic replay_needed = 0, is_load = 0, load_miss = 0, dst_write = 0;
   logic [SIG_W-1:0] dst_sig = 0;
   logic [TAG_W-1:0] dst_tag = 0;
   logic [ID_W-1:0]  instr_id = 0;
   logic res_valid, err_flag, flush_req;
   logic [SIG_W-1:0] res_sig;
   logic [TAG_W-1:0] res_tag;
   logic [ID_W-1:0]  flush_id;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sig_port_checker #(.SIG_W(SIG_W), .TAG_W(TAG_W), .ID_W(ID_W)) uut (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .use_a(use_a), .use_b(use_b),
      .exp_sig_a(exp_sig_a), .exp_sig_b(exp_sig_b), .opnd_sig_a(opnd_sig_a),
      .opnd_sig_b(opnd_sig_b), .replay_needed(replay_needed), .is_load(is_load),
      .load_miss(load_miss), .dst_write(dst_write), .dst_sig(dst_sig), .dst_tag(dst_tag),
      .instr_id(instr_id), .res_valid(res_valid), .res_sig(res_sig), .res_tag(res_tag),
      .err_flag(err_flag), .flush_req(flush_req), .flush_id(flush_id));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit mdl_mis();
      return issue_valid && ((use_a && opnd_sig_a != exp_sig_a) ||
                             (use_b && opnd_sig_b != exp_sig_b));
   endfunction

   function automatic bit mdl_err();
      return issue_valid && (mdl_mis() != replay_needed);
   endfunction

   function automatic logic [SIG_W-1:0] mdl_sig();
      return (mdl_mis() || (is_load && load_miss)) ? (dst_sig ^ MASK) : dst_sig;
   endfunction

   // Apply current inputs for one edge and check outputs afterwards
   task automatic step(input string tag);
      bit e_err, e_val, e_mis, e_ld;
      logic [SIG_W-1:0] e_sig;
      logic [TAG_W-1:0] e_tag;
      logic [ID_W-1:0]  e_id;
      e_err = mdl_err();
      e_val = issue_valid && dst_write;
      e_mis = mdl_mis();
      e_ld  = is_load && load_miss;
      e_sig = mdl_sig();
      e_tag = dst_tag;
      e_id  = instr_id;
      @(negedge clk);
      chk(err_flag == e_err, {tag, " R4 err_flag"}, int'(err_flag), int'(e_err));
      chk(flush_req == e_err, {tag, " R5 flush_req"}, int'(flush_req), int'(e_err));
      if (e_err) chk(flush_id == e_id, {tag, " R5 flush_id"}, int'(flush_id), int'(e_id));
      chk(res_valid == e_val, {tag, " R9 res_valid"}, int'(res_valid), int'(e_val));
      if (e_val) begin
         if (e_ld)       chk(res_sig == e_sig, {tag, " R6 load spoil"}, int'(res_sig), int'(e_sig));
         else if (e_mis) chk(res_sig == e_sig, {tag, " R7 chain spoil"}, int'(res_sig), int'(e_sig));
         else            chk(res_sig == e_sig, {tag, " R8 clean sig"}, int'(res_sig), int'(e_sig));
         chk(res_tag == e_tag, {tag, " R8 tag"}, int'(res_tag), int'(e_tag));
      end
   endtask

   task automatic idle();
      issue_valid = 0; use_a = 0; use_b = 0; replay_needed = 0;
      is_load = 0; load_miss = 0; dst_write = 0;
   endtask

   task automatic base(input logic [SIG_W-1:0] s, input logic [TAG_W-1:0] t,
                       input logic [ID_W-1:0] id);
      issue_valid = 1; use_a = 1; use_b = 1; replay_needed = 0;
      is_load = 0; load_miss = 0; dst_write = 1;
      exp_sig_a = 3'd2; opnd_sig_a = 3'd2; exp_sig_b = 3'd5; opnd_sig_b = 3'd5;
      dst_sig = s; dst_tag = t; instr_id = id;
   endtask

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h5EED_1234);
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!err_flag && !flush_req && !res_valid, "R1 in reset", int'(err_flag | res_valid), 0);
      rst_n = 1;
      @(negedge clk);
      chk(!err_flag && !flush_req && !res_valid, "R1 after release", int'(err_flag | res_valid), 0);

      // R8 clean pass
      base(3'd3, 7'd40, 6'd1); step("dir clean");
      // R4 truth table rows
      base(3'd1, 7'd41, 6'd2); replay_needed = 1; step("dir replay only");
      base(3'd1, 7'd42, 6'd3); opnd_sig_a = 3'd6; step("dir mismatch only R2");
      base(3'd4, 7'd43, 6'd4); opnd_sig_b = 3'd4; replay_needed = 1; step("dir both R7");
      // R5: single-cycle pulse after a fault
      idle(); step("dir pulse ends R5");
      // R3: unused mismatched operands
      base(3'd0, 7'd44, 6'd5); use_a = 0; use_b = 0; opnd_sig_a = 3'd7; opnd_sig_b = 3'd0;
      step("dir unused R3");
      chk(err_flag == 0, "R3 no error on unused", int'(err_flag), 0);
      // R6 load miss
      base(3'd6, 7'd45, 6'd6); is_load = 1; load_miss = 1; step("dir load miss");
      // R10 miss on non-load
      base(3'd6, 7'd46, 6'd7); load_miss = 1; step("dir R10 nonload miss");
      chk(res_sig == 3'd6, "R10 res_sig unspoiled", int'(res_sig), 6);
      // R9 invalid with fault-like inputs
      base(3'd2, 7'd47, 6'd8); issue_valid = 0; opnd_sig_a = 3'd1; replay_needed = 1;
      step("dir R9 invalid");
      base(3'd2, 7'd48, 6'd9); dst_write = 0; step("dir R9 no dst");

      // Random traffic
      for (int i = 0; i < 2000; i++) begin
         issue_valid = ($urandom % 8) != 0;
         use_a = $urandom % 2; use_b = ($urandom % 4) != 0;
         exp_sig_a = $urandom; exp_sig_b = $urandom;
         opnd_sig_a = (($urandom % 10) < 7) ? exp_sig_a : exp_sig_a ^ SIG_W'(1 + $urandom % 7);
         opnd_sig_b = (($urandom % 10) < 7) ? exp_sig_b : exp_sig_b ^ SIG_W'(1 + $urandom % 7);
         replay_needed = ($urandom % 4) == 0;
         is_load = $urandom % 2; load_miss = ($urandom % 3) == 0;
         dst_write = ($urandom % 5) != 0;
         dst_sig = $urandom; dst_tag = $urandom; instr_id = $urandom;
         step("rnd");
      end
      idle(); step("tail");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule